// File: doc/BRIEF.md
# Programmable Root Timer Bank

The block holds three independent 16-bit up-counters that software reaches through a small register bus. Each timer has a mode word, a compare value and a live count value. It counts either the system clock or an alternative source of its own. Timer 0 uses an external pixel-rate enable, timer 1 uses horizontal-sync pulses, and timer 2 uses the system clock divided by eight. Timer 2 can also be halted outright.

Each timer compares its count with its compare value. It can either wrap back to zero on a match or run on to the 16-bit overflow. It records a match in a sticky flag inside the mode word, and it can raise an interrupt on a match, on an overflow, or on both. The interrupt can be one-shot, firing once until software rewrites the mode word, or it can fire on every qualifying event. The interrupt controller and the generation of the pixel and sync strobes lie outside the block.

Top module: `rtRootTimer`

## Requirements
- R1: After reset every count, mode word and compare value reads as zero, and all interrupt outputs are low.
- R2: Timer `i` sits at bus address `0x10*i`, with the count at offset 0x0, the mode word at 0x4 and the compare value at 0x8. A compare write reads back unchanged, and count writes are ignored.
- R3: A mode write stores bits 0, 3, 4, 5, 6 and 8, which read back, and all other bits read as zero. The write also clears the count to zero, clears the match flag and re-arms the interrupt latch.
- R4: With mode bit 8 clear, the count rises by one per system clock and wraps from 0xFFFF to 0x0000.
- R5: With mode bit 8 set, timer 0 advances once per clock in which the pixel enable input is high.
- R6: With mode bit 8 set, timer 1 advances once per clock in which the hsync input is high.
- R7: With mode bit 8 set, timer 2 advances once every 8 system clocks, and a mode write restarts this prescaler. Mode bit 0 stops timer 2 so that its count holds. Bit 0 has no effect on timers 0 and 1.
- R8: With mode bit 3 set, a count that would step onto the compare value is loaded with zero instead, giving a period of exactly that many ticks. With bit 3 clear, the count passes the compare value and keeps counting.
- R9: Mode bit 4 enables an interrupt on a compare match and bit 5 enables one on overflow. Each interrupt is a one-cycle pulse that rises in the same cycle as the count update that caused it.
- R10: With mode bit 6 clear, only the first qualifying event after a mode write raises the interrupt. With bit 6 set, every event raises it.
- R11: Mode bit 11 reads as 1 once a match has occurred. A bus read of the mode word returns the flag and then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-rate enable, alternative source for timer 0 |
| hsync | input | 1 | Horizontal sync pulse, alternative source for timer 1 |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect: clears match flag on mode reads) |
| addr | input | 8 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| irq | output | 3 | One interrupt pulse line per timer |

## Verification
The count path is tried with the plain system clock, with the three alternative sources and with the timer 2 halt. Each case uses a known number of ticks, so a wrong prescale ratio, a source routed to the wrong timer or a halt that leaks shows up as a different count.

The compare path is run with wrap-on-match both set and clear, using compare values that differ between runs. This separates a period of N ticks from one of N+1 ticks, and separates a wrap from a free run. Interrupt pulses are counted over windows holding ten matches, in both one-shot and repeat modes, and again after a re-arming mode write. A full 65536-cycle run then covers the wrap to zero and the overflow interrupt.

// File: rtl/rtTimerPkg.sv
package rtTimerPkg;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 8;
  localparam int BIT_DIS  = 0;
  localparam int BIT_ROT  = 3;
  localparam int BIT_IRQT = 4;
  localparam int BIT_IRQO = 5;
  localparam int BIT_REP  = 6;
  localparam int BIT_ALT  = 8;
  localparam int BIT_FLAG = 11;
  localparam logic [CNT_W-1:0] MODE_MASK = CNT_W'(16'h0179);

  localparam logic [3:0] OFS_CNT  = 4'h0;
  localparam logic [3:0] OFS_MODE = 4'h4;
  localparam logic [3:0] OFS_TGT  = 4'h8;

  typedef struct packed {
    logic tick;
    logic modeWr;
    logic tgtWr;
    logic modeRd;
  } tmrStrobe_t;
endpackage

// File: rtl/rtTimerCtrl.sv
module rtTimerCtrl
  import rtTimerPkg::*;
#(
  parameter int IDX     = 0,
  parameter int ALT_DIV = 1,
  parameter bit HAS_DIS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              altIn,
  input  logic              modeAlt,
  input  logic              modeDis,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output tmrStrobe_t        strb
);
  localparam int SEL_W = ADDR_W - 4;

  logic selMe;
  logic altTick;
  logic stopped;

  assign selMe = (addr[ADDR_W-1:4] == SEL_W'(IDX));

  generate
    if (ALT_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(ALT_DIV);
      logic [PRE_W-1:0] preCnt;
      logic             preWrap;
      assign preWrap = (preCnt == PRE_W'(ALT_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN || strb.modeWr) preCnt <= '0;
        else if (altIn)           preCnt <= preWrap ? '0 : preCnt + 1'b1;
      end
      assign altTick = altIn && preWrap;

      // R7
      alt_no_back2back_chk: assert property (@(posedge clk) disable iff (!rstN)
        (modeAlt && strb.tick && !strb.modeWr) |=> !strb.tick);
    end else begin : g_direct
      assign altTick = altIn;
    end
  endgenerate

  assign stopped     = HAS_DIS && modeDis;
  assign strb.tick   = !stopped && (modeAlt ? altTick : 1'b1);
  assign strb.modeWr = wrEn && selMe && (addr[3:0] == OFS_MODE);
  assign strb.tgtWr  = wrEn && selMe && (addr[3:0] == OFS_TGT);
  assign strb.modeRd = rdEn && selMe && (addr[3:0] == OFS_MODE);
endmodule

// File: rtl/rtTimerDatapath.sv
module rtTimerDatapath
  import rtTimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] modeView,
  output logic             modeAlt,
  output logic             modeDis,
  output logic             irq
);
  logic [CNT_W-1:0] modeReg;
  logic [CNT_W-1:0] nextCnt;
  logic             flag;
  logic             latched;
  logic             hit;
  logic             ovf;
  logic             fire;

  assign nextCnt = count + 1'b1;
  assign hit     = strb.tick && (nextCnt == target);
  assign ovf     = strb.tick && (count == {CNT_W{1'b1}});
  assign fire    = ((hit && modeReg[BIT_IRQT]) || (ovf && modeReg[BIT_IRQO]))
                   && (modeReg[BIT_REP] || !latched);

  assign modeAlt  = modeReg[BIT_ALT];
  assign modeDis  = modeReg[BIT_DIS];
  assign modeView = modeReg | (CNT_W'(flag) << BIT_FLAG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      modeReg <= '0;
      flag    <= 1'b0;
      latched <= 1'b0;
      irq     <= 1'b0;
    end else if (strb.modeWr) begin
      count   <= '0;
      modeReg <= wdata & MODE_MASK;
      flag    <= 1'b0;
      latched <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) latched <= 1'b1;
      if (strb.tick) count <= (hit && modeReg[BIT_ROT]) ? '0 : nextCnt;
      if (hit)              flag <= 1'b1;
      else if (strb.modeRd) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            target <= '0;
    else if (strb.tgtWr)  target <= wdata;
  end

  // R3
  mode_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> (count == '0) && !irq && !flag);

  // R8
  wrap_on_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.modeWr && modeReg[BIT_ROT] && (nextCnt == target)) |=> (count == '0));

  // R9
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(strb.tick));

  // R10
  oneshot_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !modeReg[BIT_REP]) |=> !irq);

  // R11
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.modeWr && (nextCnt == target)) |=> flag);

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.modeWr) |=> $stable(count));
endmodule

// File: rtl/rtRootTimer.sv
module rtRootTimer
  import rtTimerPkg::*;
#(
  parameter int T2_DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              hsync,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [2:0]        irq
);
  localparam int NUM_TMR = 3;

  tmrStrobe_t       strb     [NUM_TMR];
  logic [CNT_W-1:0] count    [NUM_TMR];
  logic [CNT_W-1:0] target   [NUM_TMR];
  logic [CNT_W-1:0] modeView [NUM_TMR];
  logic             modeAlt  [NUM_TMR];
  logic             modeDis  [NUM_TMR];

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      logic altIn;
      if (i == 0)      begin : g_s0 assign altIn = pixEn; end
      else if (i == 1) begin : g_s1 assign altIn = hsync; end
      else             begin : g_s2 assign altIn = 1'b1;  end

      rtTimerCtrl #(
        .IDX    (i),
        .ALT_DIV((i == 2) ? T2_DIV : 1),
        .HAS_DIS(i == 2)
      ) u_ctrl (
        .clk    (clk),
        .rstN   (rstN),
        .altIn  (altIn),
        .modeAlt(modeAlt[i]),
        .modeDis(modeDis[i]),
        .wrEn   (wrEn),
        .rdEn   (rdEn),
        .addr   (addr),
        .strb   (strb[i])
      );

      rtTimerDatapath u_dp (
        .clk     (clk),
        .rstN    (rstN),
        .strb    (strb[i]),
        .wdata   (wdata),
        .count   (count[i]),
        .target  (target[i]),
        .modeView(modeView[i]),
        .modeAlt (modeAlt[i]),
        .modeDis (modeDis[i]),
        .irq     (irq[i])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr[ADDR_W-1:4] == (ADDR_W-4)'(i)) begin
        case (addr[3:0])
          OFS_CNT:  rdata = count[i];
          OFS_MODE: rdata = modeView[i];
          OFS_TGT:  rdata = target[i];
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/rtRootTimer_tb.sv
module rtRootTimer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic        hsync = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  int irqSeen = 0;
  int dblPulse = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtRootTimer u_dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .hsync(hsync),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // {timer[63:60], mode[59:44], target[43:28], wait[27:16], expected count[15:0]}
  localparam logic [63:0] VEC [8] = '{
    {4'd0, 16'h0000, 16'd0,  12'd100, 16'd100}, // R4 free count
    {4'd0, 16'h0008, 16'd10, 12'd25,  16'd5},   // R8 wrap at 10
    {4'd1, 16'h0008, 16'd7,  12'd20,  16'd6},   // R8 wrap at 7
    {4'd0, 16'h0000, 16'd10, 12'd25,  16'd25},  // R8 no wrap passes target
    {4'd2, 16'h0000, 16'd0,  12'd33,  16'd33},  // R4 timer 2 sys clock
    {4'd2, 16'h0100, 16'd0,  12'd33,  16'd4},   // R7 divide by 8
    {4'd2, 16'h0101, 16'd0,  12'd40,  16'd0},   // R7 halted
    {4'd0, 16'h0001, 16'd0,  12'd10,  16'd10}   // R7 bit 0 ignored on timer 0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // sample without consuming a clock edge
  task automatic peek(input logic [7:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  // bus read: consumes one edge (mode flag clears)
  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; rdEn = 1'b1; #0.5; d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitClk(input int n, input int idx);
    logic prev = 1'b0;
    irqSeen = 0; dblPulse = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq[idx]) irqSeen++;
      if (irq[idx] && prev) dblPulse++;
      prev = irq[idx];
    end
  endtask

  task automatic pulse(input int n, input bit isPix);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (isPix) pixEn = 1'b1; else hsync = 1'b1;
      @(negedge clk);
      pixEn = 1'b0; hsync = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int t = 0; t < 3; t++) begin
      peek(8'(t*16),     v); chk("R1 count", v, 16'h0);
      peek(8'(t*16 + 4), v); chk("R1 mode",  v, 16'h0);
      peek(8'(t*16 + 8), v); chk("R1 target", v, 16'h0);
    end
    chk("R1 irq", {13'b0, irq}, 16'h0);
    @(negedge clk); rstN = 1'b1;

    // table walk: R4 R7 R8
    for (int r = 0; r < 8; r++) begin
      logic [7:0] base;
      base = 8'(VEC[r][63:60] * 16);
      wr(base + 8'h8, VEC[r][43:28]);
      wr(base + 8'h4, VEC[r][59:44]);
      waitClk(int'(VEC[r][27:16]), int'(VEC[r][63:60]));
      peek(base, v);
      chk($sformatf("R4/R7/R8 row %0d", r), v, VEC[r][15:0]);
    end

    // R2 target readback and address map, count writes ignored
    wr(8'h08, 16'h1234); wr(8'h18, 16'hABCD); wr(8'h28, 16'h0F0F);
    peek(8'h08, v); chk("R2 tgt0", v, 16'h1234);
    peek(8'h18, v); chk("R2 tgt1", v, 16'hABCD);
    peek(8'h28, v); chk("R2 tgt2", v, 16'h0F0F);
    wr(8'h24, 16'h0001);           // timer 2 halted, count 0
    wr(8'h20, 16'h5555);
    peek(8'h20, v); chk("R2 count write ignored", v, 16'h0);

    // R3 mode mask and clearing
    wr(8'h04, 16'hFFFF);
    peek(8'h04, v); chk("R3 mode mask", v, 16'h0179);
    peek(8'h00, v); chk("R3 count cleared", v, 16'h0);

    // R5 pixel source
    wr(8'h04, 16'h0100);
    pulse(6, 1'b1);
    peek(8'h00, v); chk("R5 pixel ticks", v, 16'd6);

    // R6 hsync source
    wr(8'h14, 16'h0100);
    pulse(9, 1'b0);
    peek(8'h10, v); chk("R6 hsync ticks", v, 16'd9);

    // R11 match flag
    wr(8'h08, 16'd5);
    wr(8'h04, 16'h0008);
    waitClk(7, 0);
    rd(8'h04, v); chk("R11 flag set", v, 16'h0808);
    rd(8'h04, v); chk("R11 flag cleared by read", v, 16'h0008);
    wr(8'h08, 16'd20);
    wr(8'h04, 16'h0000);
    waitClk(10, 0);
    peek(8'h04, v); chk("R11 no flag before match", v, 16'h0000);

    // R9 R10 interrupts
    wr(8'h08, 16'd5);
    wr(8'h04, 16'h0018);
    waitClk(50, 0);
    chk("R10 one-shot count", 16'(irqSeen), 16'd1);
    wr(8'h04, 16'h0018);
    waitClk(10, 0);
    chk("R10 re-armed by mode write", 16'(irqSeen), 16'd1);
    wr(8'h04, 16'h0058);
    waitClk(50, 0);
    chk("R10 repeat count", 16'(irqSeen), 16'd10);
    chk("R9 single-cycle pulse", 16'(dblPulse), 16'd0);
    wr(8'h04, 16'h0008);
    waitClk(20, 0);
    chk("R9 no irq when disabled", 16'(irqSeen), 16'd0);

    // R4 wrap and R9 overflow interrupt
    wr(8'h18, 16'h0000);
    wr(8'h14, 16'h0020);
    waitClk(65535, 1);
    peek(8'h10, v); chk("R4 reaches 0xFFFF", v, 16'hFFFF);
    chk("R9 no early overflow irq", 16'(irqSeen), 16'd0);
    waitClk(1, 1);
    peek(8'h10, v); chk("R4 wraps to zero", v, 16'h0000);
    chk("R9 overflow irq", 16'(irqSeen), 16'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule